// File: doc/BRIEF.md
# Issue-Slot Bottleneck Accounting Unit

This unit watches a four-wide issue boundary between an instruction front end and an execution back end, and sorts each of the four issue slots of every clock into exactly one of four bottleneck categories. A slot that carries a uop to normal completion counts as retiring, and a uop cancelled by a flush counts as bad speculation. An empty slot counts as back-end bound when the back end had no room for it, and as front-end bound when the back end had room but nothing arrived. Each category has its own saturating event counter, and a fifth counter records the cycles that were counted. When retired plus cancelled uops match the issued uops over an interval, the four category totals add up to four times the cycle count.

Each clock the pipeline reports five small counts: the uops the front end could deliver, the free back-end slots, the uops issued, the uops retired and the uops cancelled. Counts that cannot be true are corrected and raise a sticky error flag. A synchronous clear zeroes every counter and the flag. A freeze input pauses all counting. Any counter can be read through a select input, and the value appears one clock later.

Top module: `slot_acct_top`

## Requirements
- R1: When every counted cycle has retired plus cancelled equal to issued, the four category counters always sum to SLOTS (4) times the cycle counter.
- R2: The retiring counter (select 0) grows each counted cycle by the retired count, after the count is clamped to at most 4.
- R3: The bad-speculation counter (select 1) grows each counted cycle by the cancelled count, after the count is clamped to at most 4.
- R4: With empty = 4 − issued and blocked = 4 − back-end room, the back-end-bound counter (select 3) grows by min(empty, blocked) and the front-end-bound counter (select 2) grows by the rest of the empty slots.
- R5: The cycle counter (select 4) grows by one on each clock edge where freeze and clear are both low.
- R6: Every counter stops at its all-ones maximum and never wraps.
- R7: Clear zeroes all five counters and the error flag on one clock edge, and it takes priority over freeze.
- R8: While freeze is high, no counter and no error flag changes, whatever the other inputs do.
- R9: Any input count above 4 is treated as 4 and sets the error flag. The flag stays set until clear or reset.
- R10: An issued count above the front-end count is lowered to that count, and a back-end room below the issued count is raised to it. Each of these sets the error flag.
- R11: rd_data shows the counter picked by rd_sel one clock after rd_sel is applied. Selects 5 to 7 read zero.
- R12: After reset, all counters, rd_data and the error flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of counters and error flag |
| frz | input | 1 | Freeze: pause all counting |
| fe_avail | input | 3 | Uops the front end could deliver this cycle |
| be_room | input | 3 | Uops the back end could accept this cycle |
| n_issue | input | 3 | Uops issued this cycle |
| n_retire | input | 3 | Uops retired this cycle |
| n_flush | input | 3 | Issued uops cancelled by a flush this cycle |
| rd_sel | input | 3 | Counter select: 0 retiring, 1 bad speculation, 2 front-end bound, 3 back-end bound, 4 cycles |
| rd_data | output | 48 | Registered value of the selected counter |
| err_flag | output | 1 | Sticky flag for impossible input counts |

## Verification
On every cycle the assertions check four things: the issued, front-end-bound and back-end-bound slots together fill all four slots, and the corrected back-end room is never below the issued count. They also check that counters never move backwards except on clear, and that freeze holds every count. Clear zeroing, and the error flag staying set, are checked every cycle too. Only the bench scenarios can show the exact split of empty slots for each mix of room and issue, and the correction of bad counts. The same holds for the long-run identity between the category totals and four times the cycles, and for saturation, which the bench shows on a narrow second instance.

// File: rtl/slot_acct_pkg.sv
package slot_acct_pkg;
  // Counter slots in the bank; order is the rd_sel encoding.
  typedef enum int unsigned {
    CNT_RETIRE  = 0,
    CNT_BADSPEC = 1,
    CNT_FEBOUND = 2,
    CNT_BEBOUND = 3,
    CNT_CYCLES  = 4
  } cnt_idx_e;

  localparam int unsigned NUM_CAT = 4;
  localparam int unsigned NUM_CNT = 5;
endpackage

// File: rtl/slot_acct_sanitize.sv
module slot_acct_sanitize #(
  parameter int SLOTS = 4,
  parameter int NW    = 3
) (
  input  logic [NW-1:0] fe_avail,
  input  logic [NW-1:0] be_room,
  input  logic [NW-1:0] n_issue,
  input  logic [NW-1:0] n_retire,
  input  logic [NW-1:0] n_flush,
  output logic [NW-1:0] s_issue,
  output logic [NW-1:0] s_room,
  output logic [NW-1:0] s_retire,
  output logic [NW-1:0] s_flush,
  output logic          bad
);
  localparam logic [NW-1:0] LIM = NW'(SLOTS);

  logic [NW-1:0] c_fe, c_room, c_iss;
  logic          over;

  function automatic logic [NW-1:0] clip(input logic [NW-1:0] v);
    return (v > LIM) ? LIM : v;
  endfunction

  always_comb begin
    c_fe     = clip(fe_avail);
    c_room   = clip(be_room);
    c_iss    = clip(n_issue);
    s_retire = clip(n_retire);
    s_flush  = clip(n_flush);
    over     = (fe_avail > LIM) || (be_room > LIM) || (n_issue > LIM) ||
               (n_retire > LIM) || (n_flush > LIM);
    s_issue  = (c_iss > c_fe) ? c_fe : c_iss;
    s_room   = (c_room < s_issue) ? s_issue : c_room;
    bad      = over || (c_iss > c_fe) || (c_room < s_issue);
  end
endmodule

// File: rtl/slot_acct_classify.sv
module slot_acct_classify #(
  parameter int SLOTS = 4,
  parameter int NW    = 3
) (
  input  logic [NW-1:0] s_issue,
  input  logic [NW-1:0] s_room,
  output logic [NW-1:0] inc_fe,
  output logic [NW-1:0] inc_be
);
  localparam logic [NW-1:0] LIM = NW'(SLOTS);

  logic [NW-1:0] empty, blocked;

  always_comb begin
    empty   = LIM - s_issue;
    blocked = LIM - s_room;
    inc_be  = (blocked < empty) ? blocked : empty;
    inc_fe  = empty - inc_be;
  end
endmodule

// File: rtl/slot_acct_satcnt.sv
module slot_acct_satcnt #(
  parameter int CW = 48,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [IW-1:0] inc,
  output logic [CW-1:0] cnt
);
  logic [CW:0]   sum;
  logic [CW-1:0] nxt;

  always_comb begin
    sum = {1'b0, cnt} + (CW+1)'(inc);
    nxt = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (en)
      cnt <= nxt;
  end
endmodule

// File: rtl/slot_acct_top.sv
module slot_acct_top
  import slot_acct_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int CW    = 48,
  localparam int NW   = $clog2(SLOTS + 1),
  localparam int SELW = $clog2(NUM_CNT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            frz,
  input  logic [NW-1:0]   fe_avail,
  input  logic [NW-1:0]   be_room,
  input  logic [NW-1:0]   n_issue,
  input  logic [NW-1:0]   n_retire,
  input  logic [NW-1:0]   n_flush,
  input  logic [SELW-1:0] rd_sel,
  output logic [CW-1:0]   rd_data,
  output logic            err_flag
);
  logic [NW-1:0] s_issue, s_room, s_retire, s_flush;
  logic [NW-1:0] inc_fe, inc_be;
  logic          bad;
  logic          count_en;

  logic [NUM_CNT-1:0][NW-1:0] incs;
  logic [NUM_CNT-1:0][CW-1:0] cnt;
  logic [CW-1:0]              rd_nxt;

  slot_acct_sanitize #(.SLOTS(SLOTS), .NW(NW)) u_san (
    .fe_avail (fe_avail),
    .be_room  (be_room),
    .n_issue  (n_issue),
    .n_retire (n_retire),
    .n_flush  (n_flush),
    .s_issue  (s_issue),
    .s_room   (s_room),
    .s_retire (s_retire),
    .s_flush  (s_flush),
    .bad      (bad)
  );

  slot_acct_classify #(.SLOTS(SLOTS), .NW(NW)) u_cls (
    .s_issue (s_issue),
    .s_room  (s_room),
    .inc_fe  (inc_fe),
    .inc_be  (inc_be)
  );

  assign count_en = !frz;

  always_comb begin
    incs              = '0;
    incs[CNT_RETIRE]  = s_retire;
    incs[CNT_BADSPEC] = s_flush;
    incs[CNT_FEBOUND] = inc_fe;
    incs[CNT_BEBOUND] = inc_be;
    incs[CNT_CYCLES]  = NW'(1);
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    slot_acct_satcnt #(.CW(CW), .IW(NW)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (clr),
      .en  (count_en),
      .inc (incs[g]),
      .cnt (cnt[g])
    );
  end

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (rd_sel == SELW'(i))
        rd_nxt = cnt[i];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else
      rd_data <= rd_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      err_flag <= 1'b0;
    else if (count_en && bad)
      err_flag <= 1'b1;
  end
endmodule

// File: rtl/slot_acct_chk.sv
module slot_acct_chk
  import slot_acct_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int CW    = 48,
  parameter int NW    = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       clr,
  input logic                       frz,
  input logic [NW-1:0]              s_issue,
  input logic [NW-1:0]              s_room,
  input logic [NW-1:0]              inc_fe,
  input logic [NW-1:0]              inc_be,
  input logic [NUM_CNT-1:0][CW-1:0] cnt,
  input logic                       err_flag
);
  AST_SLOTS_FILLED: assert property (@(posedge clk) disable iff (rst)
    (32'(s_issue) + 32'(inc_fe) + 32'(inc_be)) == SLOTS); // R4

  AST_ROOM_COVERS_ISSUE: assert property (@(posedge clk) disable iff (rst)
    s_room >= s_issue); // R10

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0) && !err_flag); // R7

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (frz && !clr) |=> ($stable(cnt) && $stable(err_flag))); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !clr) |=> err_flag); // R9

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_mono
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      !clr |=> cnt[g] >= $past(cnt[g])); // R6
  end
endmodule

bind slot_acct_top slot_acct_chk #(.SLOTS(SLOTS), .CW(CW), .NW(NW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr      (clr),
  .frz      (frz),
  .s_issue  (s_issue),
  .s_room   (s_room),
  .inc_fe   (inc_fe),
  .inc_be   (inc_be),
  .cnt      (cnt),
  .err_flag (err_flag)
);

// File: tb/slot_acct_top_test.sv
`timescale 1ns/1ps
module slot_acct_top_test;
  logic clk = 1'b0;
  logic rst, clr, frz;
  logic [2:0] fe_avail, be_room, n_issue, n_retire, n_flush, rd_sel;
  logic [47:0] rd_data;
  logic [3:0]  rd_data_s;
  logic err_flag, err_flag_s;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  slot_acct_top uut (
    .clk(clk), .rst(rst), .clr(clr), .frz(frz),
    .fe_avail(fe_avail), .be_room(be_room), .n_issue(n_issue),
    .n_retire(n_retire), .n_flush(n_flush), .rd_sel(rd_sel),
    .rd_data(rd_data), .err_flag(err_flag)
  );

  // Narrow counters so saturation (R6) is reachable.
  slot_acct_top #(.CW(4)) uut_small (
    .clk(clk), .rst(rst), .clr(clr), .frz(frz),
    .fe_avail(fe_avail), .be_room(be_room), .n_issue(n_issue),
    .n_retire(n_retire), .n_flush(n_flush), .rd_sel(rd_sel),
    .rd_data(rd_data_s), .err_flag(err_flag_s)
  );

  // {fe, room, issue, retire, flush, exp_ret, exp_bs, exp_fe, exp_be, exp_err}
  localparam int NV = 11;
  localparam logic [27:0] VEC [NV] = '{
    {3'd4,3'd4,3'd4,3'd4,3'd0, 3'd4,3'd0,3'd0,3'd0, 1'b0},
    {3'd4,3'd4,3'd0,3'd0,3'd0, 3'd0,3'd0,3'd4,3'd0, 1'b0},
    {3'd4,3'd0,3'd0,3'd0,3'd0, 3'd0,3'd0,3'd0,3'd4, 1'b0},
    {3'd3,3'd2,3'd2,3'd1,3'd1, 3'd1,3'd1,3'd0,3'd2, 1'b0},
    {3'd1,3'd4,3'd1,3'd1,3'd0, 3'd1,3'd0,3'd3,3'd0, 1'b0},
    {3'd4,3'd3,3'd2,3'd2,3'd0, 3'd2,3'd0,3'd1,3'd1, 1'b0},
    {3'd0,3'd0,3'd0,3'd0,3'd0, 3'd0,3'd0,3'd0,3'd4, 1'b0},
    {3'd2,3'd4,3'd0,3'd0,3'd3, 3'd0,3'd3,3'd4,3'd0, 1'b0},
    {3'd7,3'd4,3'd6,3'd5,3'd0, 3'd4,3'd0,3'd0,3'd0, 1'b1},
    {3'd2,3'd4,3'd3,3'd3,3'd0, 3'd3,3'd0,3'd2,3'd0, 1'b1},
    {3'd4,3'd1,3'd3,3'd3,3'd0, 3'd3,3'd0,3'd0,3'd1, 1'b1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, output logic [47:0] v, output logic [3:0] vs);
    @(negedge clk) rd_sel = s;
    @(negedge clk);
    v  = rd_data;
    vs = rd_data_s;
  endtask

  task automatic drive(input logic [2:0] f, r, i, t, c);
    fe_avail = f; be_room = r; n_issue = i; n_retire = t; n_flush = c;
  endtask

  task automatic do_clear();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  function automatic logic [63:0] sat4(input longint v);
    return (v > 15) ? 64'd15 : 64'(v);
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] v;
    logic [3:0]  vs;
    longint e_ret, e_bs, e_fe, e_be, e_cyc;
    rst = 1'b1; clr = 1'b0; frz = 1'b1; rd_sel = '0;
    drive(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    check("R12 err", 64'(err_flag), 0);
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), v, vs);
      check("R12 counter", 64'(v), 0);
    end

    // Table walk: one counted cycle per entry. R2 R3 R4 R9 R10
    for (int k = 0; k < NV; k++) begin
      do_clear();
      @(negedge clk);
      drive(VEC[k][27:25], VEC[k][24:22], VEC[k][21:19], VEC[k][18:16], VEC[k][15:13]);
      frz = 1'b0;
      @(negedge clk);
      frz = 1'b1;
      drive(0, 0, 0, 0, 0);
      check("R9 R10 err flag", 64'(err_flag), 64'(VEC[k][0]));
      rd(3'd0, v, vs); check("R2 retire", 64'(v), 64'(VEC[k][12:10]));
      rd(3'd1, v, vs); check("R3 badspec", 64'(v), 64'(VEC[k][9:7]));
      rd(3'd2, v, vs); check("R4 fe bound", 64'(v), 64'(VEC[k][6:4]));
      rd(3'd3, v, vs); check("R4 be bound", 64'(v), 64'(VEC[k][3:1]));
      rd(3'd4, v, vs); check("R5 cycles", 64'(v), 1);
    end

    // R11 unmapped selects read zero (counters nonzero after last entry)
    for (int s = 5; s < 8; s++) begin
      rd(3'(s), v, vs);
      check("R11 unmapped select", 64'(v), 0);
    end

    // Random consistent traffic with frozen gaps. R1 R5 R8 R6
    do_clear();
    e_ret = 0; e_bs = 0; e_fe = 0; e_be = 0; e_cyc = 0;
    for (int n = 0; n < 600; n++) begin
      int iss, fe, room, ret, be;
      @(negedge clk);
      iss  = $urandom % 5;
      fe   = iss + ($urandom % (5 - iss));
      room = iss + ($urandom % (5 - iss));
      ret  = $urandom % (iss + 1);
      frz  = (($urandom % 8) == 0);
      drive(3'(fe), 3'(room), 3'(iss), 3'(ret), 3'(iss - ret));
      if (!frz) begin
        be = ((4 - room) < (4 - iss)) ? (4 - room) : (4 - iss);
        e_ret += ret; e_bs += iss - ret; e_be += be; e_fe += (4 - iss) - be;
        e_cyc++;
      end
    end
    @(negedge clk);
    frz = 1'b1;
    // Frozen with active inputs: nothing may move (R8)
    drive(4, 4, 4, 4, 0);
    repeat (10) @(negedge clk);
    rd(3'd0, v, vs); check("R2 R8 retire total", 64'(v), 64'(e_ret)); check("R6 small retire", 64'(vs), sat4(e_ret));
    begin
      longint sum;
      sum = longint'(v);
      rd(3'd1, v, vs); check("R3 badspec total", 64'(v), 64'(e_bs)); check("R6 small badspec", 64'(vs), sat4(e_bs));
      sum += longint'(v);
      rd(3'd2, v, vs); check("R4 fe total", 64'(v), 64'(e_fe)); check("R6 small fe", 64'(vs), sat4(e_fe));
      sum += longint'(v);
      rd(3'd3, v, vs); check("R4 be total", 64'(v), 64'(e_be)); check("R6 small be", 64'(vs), sat4(e_be));
      sum += longint'(v);
      rd(3'd4, v, vs); check("R5 cycle total", 64'(v), 64'(e_cyc)); check("R6 small cycles", 64'(vs), 15);
      check("R1 slot sum", 64'(sum), 64'(4 * longint'(v)));
    end
    check("R8 no error from frozen bad-free run", 64'(err_flag), 0);

    // R9 sticky error across good cycles
    @(negedge clk); drive(4, 2, 4, 4, 0); frz = 1'b0;   // room<issue -> error
    @(negedge clk); drive(4, 4, 2, 2, 0);
    repeat (4) @(negedge clk);
    frz = 1'b1;
    check("R9 sticky err", 64'(err_flag), 1);

    // R7 clear with freeze held and active inputs
    drive(4, 4, 4, 4, 0);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    check("R7 err cleared", 64'(err_flag), 0);
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), v, vs);
      check("R7 counter cleared", 64'(v), 0);
    end

    // R7 clear while unfrozen wins over counting
    @(negedge clk) frz = 1'b0; clr = 1'b1;
    @(negedge clk) frz = 1'b1; clr = 1'b0;
    rd(3'd4, v, vs); check("R7 clear beats count", 64'(v), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule